// File: doc/BRIEF.md
# Ethernet Receive Frame Error Classifier

This block follows one incoming Ethernet frame, one bit per valid cycle, and produces the receive status that is written when the frame's buffer descriptor is closed. It needs four inputs: a valid and last-bit marker for the bit stream, a strobe that reports a receive FIFO overrun, and a CRC-match flag from an external CRC engine. The CRC flag matters only on the cycle that completes an octet. The block counts whole octets, tracks any trailing partial octet, and compares the octet count with a programmable maximum length.

It reports four status flags: overrun (`st_ov`), non-octet-aligned with a bad CRC (`st_no`), aligned with a bad CRC (`st_cr`) and over-long frame (`st_lg`). It also drives a one-cycle descriptor-close strobe, a one-cycle babbling-receive interrupt strobe, and a per-octet keep signal. The keep signal tells the buffer writer which octets to store, and it drops every octet beyond the truncation limit. CRC checking has no disable input. A user who does not care about CRC results ignores `st_no` and `st_cr`.

Top module: `rxerr_classifier`

## Requirements
- R1: After reset, `st_ov`, `st_no`, `st_cr`, `st_lg`, `desc_close` and `babble_irq` are all 0.
- R2: A `fifo_ovr` pulse on a frame bit has the following effects:
  - `desc_close` pulses on the next cycle with `st_ov`=1 and `st_no`=`st_cr`=0.
  - For the rest of that frame up to its last bit, `byte_keep` stays 0 and no further close occurs.
- R3: If a frame ends with 1 to 7 bits after its last whole octet, the CRC flag sampled on that last whole octet decides the result. If that flag was 0, `st_no`=1 and `st_cr`=0.
- R4: If a frame ends with 1 to 7 trailing bits and the CRC flag on the last whole octet was 1, no error is reported. This holds even when `crc_ok` is 0 during the trailing bits.
- R5: If a frame ends exactly on an octet boundary and `crc_ok` is 0 on its final bit, `st_cr`=1 and `st_no`=0.
- R6: CRC evaluation is always on. An aligned frame with `crc_ok`=1 on its final bit closes with all four status flags 0.
- R7: When an octet completes and the octet count becomes greater than `max_len`, the following happens:
  - `babble_irq` pulses one cycle later, at most once per frame.
  - `st_lg` reads 1 at the close.
  - A count equal to `max_len` does not trigger either.
- R8: `byte_keep` is 1 on the completing bit of each of the first 2047 octets of a frame, and 0 for every later octet. The octet counter saturates at 2047.
- R9: The close timing and status lifetime are as follows:
  - Without an overrun, `desc_close` pulses exactly one cycle after the bit marked `bit_last`, and the status flags are valid in that cycle.
  - The flags are cleared on the cycle after the first bit of the next frame.
- R10: While `bit_valid` is 0, the status flags do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_valid | input | 1 | A frame bit is present this cycle |
| bit_last | input | 1 | This bit is the final bit of the frame |
| crc_ok | input | 1 | CRC residue matches; used on octet-completing bits |
| fifo_ovr | input | 1 | Receive FIFO overrun strobe |
| max_len | input | CNT_W | Maximum frame length in octets |
| byte_keep | output | 1 | Octet completing on this bit is to be stored |
| babble_irq | output | 1 | One-cycle over-length interrupt strobe |
| desc_close | output | 1 | One-cycle descriptor-close strobe |
| st_ov | output | 1 | Overrun status |
| st_no | output | 1 | Non-aligned frame with CRC error |
| st_cr | output | 1 | Aligned frame with CRC error |
| st_lg | output | 1 | Over-long frame status |

## Verification
The CRC verdict is tested with aligned and non-aligned frames, each with a good and a bad CRC. During those frames `crc_ok` is driven to the opposite value on every bit that does not complete an octet, so only a design that reads the flag on the last whole octet can produce the expected NO/CR/clean result. Three lengths are tried against the limit: one equal to `max_len`, one just above it, and one well beyond the truncation point. Together they separate the strict greater-than comparison, the single babble pulse and counter saturation. Two overrun frames are also run: one early in the frame and one after a babble has already fired. They show that the rest of the frame is ignored and that an `st_lg` set before the overrun is kept.

// File: rtl/rxerr_pkg.sv
package rxerr_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RECV = 2'd1,
      ST_DROP = 2'd2
   } rx_state_e;

   typedef struct packed {
      logic ov;
      logic no;
      logic cr;
      logic lg;
   } rx_stat_t;

   localparam int OCTET_BITS = 8;
   localparam int POS_W      = $clog2(OCTET_BITS);

endpackage

// File: rtl/rxerr_octet_counter.sv
module rxerr_octet_counter
   import rxerr_pkg::*;
#(
   parameter int CNT_W     = 11,
   parameter int TRUNC_LEN = 2047
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start,
   input  logic             bit_en,
   output logic             octet_done,
   output logic             octet_ok,
   output logic [POS_W-1:0] residue,
   output logic [CNT_W-1:0] cnt_after
);

   localparam logic [CNT_W-1:0] TRUNC_V = TRUNC_LEN[CNT_W-1:0];
   localparam logic [POS_W-1:0] POS_TOP = POS_W'(OCTET_BITS - 1);

   logic [POS_W-1:0] pos_q;
   logic [CNT_W-1:0] cnt_q;
   logic [POS_W-1:0] pos_eff;
   logic [CNT_W-1:0] cnt_eff;
   logic             saturated;

   // a new frame begins from zero in the same cycle its first bit arrives
   assign pos_eff    = frame_start ? '0 : pos_q;
   assign cnt_eff    = frame_start ? '0 : cnt_q;
   assign saturated  = (cnt_eff >= TRUNC_V);
   assign octet_done = bit_en && (pos_eff == POS_TOP);
   assign octet_ok   = octet_done && !saturated;
   assign residue    = bit_en ? pos_eff + 1'b1 : pos_eff;
   assign cnt_after  = octet_ok ? cnt_eff + 1'b1 : cnt_eff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
         cnt_q <= '0;
      end else if (frame_start || bit_en) begin
         pos_q <= residue;
         cnt_q <= cnt_after;
      end
   end

endmodule

// File: rtl/rxerr_judge.sv
module rxerr_judge
   import rxerr_pkg::*;
#(
   parameter int CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start,
   input  logic             octet_done,
   input  logic             crc_ok,
   input  logic [POS_W-1:0] residue,
   input  logic [CNT_W-1:0] cnt_after,
   input  logic [CNT_W-1:0] max_len,
   output logic             no_err,
   output logic             cr_err,
   output logic             over_len
);

   logic crc_held_q;
   logic held_eff;
   logic crc_final;
   logic aligned;

   assign held_eff  = frame_start ? 1'b0 : crc_held_q;
   assign aligned   = (residue == '0);
   // aligned end: this bit closes an octet, so the live flag is the boundary one
   assign crc_final = aligned ? crc_ok : held_eff;
   assign no_err    = !aligned && !crc_final;
   assign cr_err    = aligned && !crc_final;
   assign over_len  = (cnt_after > max_len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         crc_held_q <= 1'b0;
      else if (octet_done)
         crc_held_q <= crc_ok;
      else if (frame_start)
         crc_held_q <= 1'b0;
   end

endmodule

// File: rtl/rxerr_classifier.sv
module rxerr_classifier
   import rxerr_pkg::*;
#(
   parameter int CNT_W     = 11,
   parameter int TRUNC_LEN = 2047
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_valid,
   input  logic             bit_last,
   input  logic             crc_ok,
   input  logic             fifo_ovr,
   input  logic [CNT_W-1:0] max_len,
   output logic             byte_keep,
   output logic             babble_irq,
   output logic             desc_close,
   output logic             st_ov,
   output logic             st_no,
   output logic             st_cr,
   output logic             st_lg
);

   if (CNT_W < 11) begin : g_bad_width
      $error("rxerr_classifier: CNT_W must be at least 11");
   end
   if (TRUNC_LEN < 1 || TRUNC_LEN >= (1 << CNT_W)) begin : g_bad_trunc
      $error("rxerr_classifier: TRUNC_LEN must fit in CNT_W bits");
   end

   rx_state_e        state_q, state_d;
   rx_stat_t         stat_q, stat_d;
   logic             close_q, close_d;
   logic             babble_q;
   logic             babbled_q, babbled_d;

   logic             start, active, ovr_hit, ending;
   logic             octet_done, octet_ok;
   logic [POS_W-1:0] residue;
   logic [CNT_W-1:0] cnt_after;
   logic             no_err, cr_err, over_len;
   logic             babble_now, lg_eff, babbled_eff;

   assign start   = bit_valid && (state_q == ST_IDLE);
   assign active  = bit_valid && (state_q != ST_DROP);
   assign ovr_hit = active && fifo_ovr;
   assign ending  = active && bit_last;

   rxerr_octet_counter #(
      .CNT_W    (CNT_W),
      .TRUNC_LEN(TRUNC_LEN)
   ) i_count (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_start(start),
      .bit_en     (active),
      .octet_done (octet_done),
      .octet_ok   (octet_ok),
      .residue    (residue),
      .cnt_after  (cnt_after)
   );

   rxerr_judge #(
      .CNT_W(CNT_W)
   ) i_judge (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_start(start),
      .octet_done (octet_done),
      .crc_ok     (crc_ok),
      .residue    (residue),
      .cnt_after  (cnt_after),
      .max_len    (max_len),
      .no_err     (no_err),
      .cr_err     (cr_err),
      .over_len   (over_len)
   );

   assign lg_eff      = start ? 1'b0 : stat_q.lg;
   assign babbled_eff = start ? 1'b0 : babbled_q;
   assign babble_now  = active && !ovr_hit && octet_done && over_len && !babbled_eff;
   assign byte_keep   = octet_ok && !ovr_hit;

   always_comb begin
      stat_d    = start ? '0 : stat_q;
      state_d   = state_q;
      close_d   = 1'b0;
      babbled_d = babbled_eff || babble_now;
      if (ovr_hit) begin
         stat_d.ov = 1'b1;
         stat_d.lg = lg_eff;
         close_d   = 1'b1;
         state_d   = bit_last ? ST_IDLE : ST_DROP;
      end else if (active) begin
         stat_d.lg = lg_eff || babble_now;
         if (ending) begin
            stat_d.no = no_err;
            stat_d.cr = cr_err;
            close_d   = 1'b1;
            state_d   = ST_IDLE;
         end else begin
            state_d   = ST_RECV;
         end
      end else if (state_q == ST_DROP && bit_valid && bit_last) begin
         state_d = ST_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         stat_q    <= '0;
         close_q   <= 1'b0;
         babble_q  <= 1'b0;
         babbled_q <= 1'b0;
      end else begin
         state_q   <= state_d;
         stat_q    <= stat_d;
         close_q   <= close_d;
         babble_q  <= babble_now;
         babbled_q <= babbled_d;
      end
   end

   assign desc_close = close_q;
   assign babble_irq = babble_q;
   assign st_ov      = stat_q.ov;
   assign st_no      = stat_q.no;
   assign st_cr      = stat_q.cr;
   assign st_lg      = stat_q.lg;

endmodule

// File: rtl/rxerr_classifier_chk.sv
module rxerr_classifier_chk #(
   parameter int CNT_W     = 11,
   parameter int TRUNC_LEN = 2047
) (
   input logic clk,
   input logic rst_n,
   input logic bit_valid,
   input logic byte_keep,
   input logic babble_irq,
   input logic desc_close,
   input logic st_ov,
   input logic st_no,
   input logic st_cr,
   input logic st_lg
);

   logic [CNT_W+1:0] kept_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         kept_q <= '0;
      else if (desc_close)
         kept_q <= '0;
      else if (byte_keep)
         kept_q <= kept_q + 1'b1;
   end

   p_ov_alone_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_close && st_ov) |-> (!st_no && !st_cr));

   p_no_cr_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      desc_close |-> !(st_no && st_cr));

   p_babble_lg_r7: assert property (@(posedge clk) disable iff (!rst_n)
      babble_irq |-> st_lg);

   p_babble_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      babble_irq |=> !babble_irq);

   p_trunc_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      kept_q <= (CNT_W+2)'(TRUNC_LEN));

   p_close_after_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      desc_close |-> $past(bit_valid));

   p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_valid |=> $stable({st_ov, st_no, st_cr, st_lg}));

endmodule

bind rxerr_classifier rxerr_classifier_chk #(
   .CNT_W    (CNT_W),
   .TRUNC_LEN(TRUNC_LEN)
) i_chk (.*);

// File: tb/test_rxerr_classifier.sv
`timescale 1ns/1ps
module test_rxerr_classifier;

   localparam int CLK_PERIOD = 10;
   localparam int CNT_W      = 11;
   localparam int TRUNC      = 2047;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             bit_valid = 1'b0;
   logic             bit_last = 1'b0;
   logic             crc_ok = 1'b0;
   logic             fifo_ovr = 1'b0;
   logic [CNT_W-1:0] max_len = 11'd1518;
   logic             byte_keep, babble_irq, desc_close;
   logic             st_ov, st_no, st_cr, st_lg;

   typedef struct {
      bit ov; bit no; bit cr; bit lg;
      int kept; int bab;
      string tag;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   errors = 0;
   int   acc_kept = 0;
   int   acc_bab = 0;
   bit   done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rxerr_classifier #(.CNT_W(CNT_W), .TRUNC_LEN(TRUNC)) i_rxerr_classifier (
      .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_last(bit_last),
      .crc_ok(crc_ok), .fifo_ovr(fifo_ovr), .max_len(max_len),
      .byte_keep(byte_keep), .babble_irq(babble_irq), .desc_close(desc_close),
      .st_ov(st_ov), .st_no(st_no), .st_cr(st_cr), .st_lg(st_lg)
   );

   task automatic chk(string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   // scoreboard monitor: reads shortly after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (rst_n && !done) begin
            if (babble_irq) acc_bab++;
            if (desc_close) begin
               if (q.size() == 0) begin
                  chk("R9 unexpected close", 1, 0);
               end else begin
                  exp_t e;
                  e = q.pop_front();
                  chk({"R2 ov ", e.tag}, st_ov, e.ov);
                  chk({"R3 no ", e.tag}, st_no, e.no);
                  chk({"R5 cr ", e.tag}, st_cr, e.cr);
                  chk({"R7 lg ", e.tag}, st_lg, e.lg);
                  chk({"R7 babble count ", e.tag}, acc_bab, e.bab);
                  chk({"R8 kept octets ", e.tag}, acc_kept, e.kept);
               end
               acc_kept = 0;
               acc_bab  = 0;
            end
            if (byte_keep) acc_kept++;
         end
      end
   end

   // driver: pushes the expected close record, then drives the bits
   task automatic send_frame(int nbits, bit good, int ovr_at, int maxl, string tag);
      exp_t e;
      int   octs, cnt;
      octs   = (ovr_at >= 0) ? ovr_at / 8 : nbits / 8;
      cnt    = (octs > TRUNC) ? TRUNC : octs;
      e.tag  = tag;
      e.kept = cnt;
      e.bab  = (cnt > maxl) ? 1 : 0;
      e.lg   = (cnt > maxl);
      e.ov   = (ovr_at >= 0);
      e.no   = (ovr_at < 0) && (nbits % 8 != 0) && !good;
      e.cr   = (ovr_at < 0) && (nbits % 8 == 0) && !good;
      q.push_back(e);
      max_len = CNT_W'(maxl);
      for (int i = 0; i < nbits; i++) begin
         bit_valid = 1'b1;
         bit_last  = (i == nbits - 1);
         fifo_ovr  = (i == ovr_at);
         crc_ok    = ((i % 8) == 7) ? good : !good;
         @(posedge clk);
         @(negedge clk);
         if (i == 0 && ovr_at != 0)
            chk({"R9 status cleared at start ", tag},
                {st_ov, st_no, st_cr, st_lg}, 0);
         if (i == ovr_at)
            chk({"R2 close after overrun ", tag}, desc_close, 1);
         if (ovr_at >= 0 && i > ovr_at)
            chk({"R2 no close after overrun ", tag}, desc_close, 0);
         if (ovr_at < 0 && i == nbits - 1)
            chk({"R9 close after last bit ", tag}, desc_close, 1);
      end
      bit_valid = 1'b0;
      bit_last  = 1'b0;
      fifo_ovr  = 1'b0;
      crc_ok    = 1'b0;
      repeat (4) @(negedge clk);
      chk({"R10 status held while idle ", tag},
          {st_ov, st_no, st_cr, st_lg}, {e.ov, e.no, e.cr, e.lg});
      chk({"R9 single close ", tag}, desc_close, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset status", {st_ov, st_no, st_cr, st_lg}, 0);
      chk("R1 reset strobes", {desc_close, babble_irq, byte_keep}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 idle after reset", {st_ov, st_no, st_cr, st_lg, desc_close}, 0);

      send_frame(512, 1'b1, -1, 1518, "R6 aligned good");
      send_frame(512, 1'b0, -1, 1518, "R5 aligned bad");
      send_frame(515, 1'b0, -1, 1518, "R3 dribble bad");
      send_frame(517, 1'b1, -1, 1518, "R4 dribble good");
      send_frame(400, 1'b1, 100, 1518, "R2 early overrun");
      send_frame(512, 1'b1, -1, 64, "R7 length equal max");
      send_frame(520, 1'b1, -1, 64, "R7 length max plus one");
      send_frame(803, 1'b0, -1, 60, "R7 long dribble bad");
      send_frame(800, 1'b1, 600, 60, "R2 overrun after babble");
      send_frame(2100 * 8, 1'b1, -1, 1518, "R8 truncated frame");
      send_frame(512, 1'b0, -1, 1518, "R5 after truncation");

      repeat (3) @(negedge clk);
      chk("R9 all closes seen", q.size(), 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule